// File: doc/BRIEF.md
# Prefix Operand Field Substitution Unit

This unit sits between the fetch latch and the register-file read ports of a small two-stage core. It gives the core indirect register addressing without pointer registers and without an extra pipeline stage. A prefix instruction names a replacement offset for the destination field, the source field, or both. The next valid instruction then has those 9-bit register-address fields patched on its way to the register RAM address inputs.

The patched field is the original field plus the low 9 bits of the prefix operand, modulo 512. A move whose source field is zero, issued after a source prefix that carries a pointer, therefore reads the register the pointer names. The prefix operand is either the register contents that the core read for the prefix, or the prefix's own field used as an immediate.

The path from the instruction word to the patched word is purely combinational. Only the pending substitution is registered. It lasts for one valid instruction, and a branch cancel throws it away.

Top module: `opatch_top`

## Requirements
- R1: After reset no substitution is pending: the first valid ordinary instruction leaves unchanged and `out_valid` follows `in_valid`.
- R2: With nothing pending, an ordinary instruction leaves with every bit unchanged.
- R3: A prefix is a word with bits [31:25] = 7'h5E and selector bits [24:23] not 00. Selector 01 replaces only the D field (bits [17:9]) of the next valid instruction. S is left alone.
- R4: Selector 10 replaces only the S field (bits [8:0]) of the next valid instruction. D is left alone.
- R5: Selector 11 replaces both fields in one step, each with its own offset.
- R6: Bit 22 set makes the D offset the prefix's own bits [17:9]; clear makes it `pfx_rd_d[8:0]`. Bit 21 selects the same way for S, between bits [8:0] and `pfx_rd_s[8:0]`.
- R7: A patched field equals the original field plus the offset, modulo 512. A zero field yields the offset exactly.
- R8: A pending substitution is consumed by exactly one following valid instruction. Cycles with `in_valid` low do not consume it, and the instruction after the consuming one is not patched.
- R9: `out_valid` is low while `cancel` is high. A cancelled instruction discards any pending substitution, and a cancelled prefix records nothing.
- R10: A prefix instruction always leaves unmodified. When two prefixes arrive back to back, the second one's settings fully replace the first one's.
- R11: Bits [31:18] are never altered. A word carrying the prefix opcode with selector 00 is an ordinary instruction.
- R12: The patched word appears in the same cycle as its input word, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word is valid this cycle |
| in_word | input | 32 | Fetched instruction word |
| cancel | input | 1 | Branch logic cancels the current instruction |
| pfx_rd_d | input | 32 | Register contents read for the prefix's D operand |
| pfx_rd_s | input | 32 | Register contents read for the prefix's S operand |
| out_word | output | 32 | Possibly patched word driving the register-file addresses |
| out_valid | output | 1 | Output word is a live instruction |

## Verification
The bench sweeps every selector with every immediate/register combination, crossing field values and offsets that include zero, 511 and carries past 511. A design that kept the carry, or took the register operand's high bits, would place the wrong address. Directed sequences cover idle gaps, cancels of the consumer and of the prefix itself, back-to-back prefixes, and selector 00. A design that let the substitution linger, survive a cancel, merge two prefixes or patch a prefix would corrupt a later address that the bench observes at the output.

// File: rtl/opatch_pkg.sv
package opatch_pkg;
    parameter int WORD_W    = 32;
    parameter int FIELD_W   = 9;
    parameter int S_LSB     = 0;
    parameter int D_LSB     = 9;
    parameter int OP_W      = 7;
    parameter int OP_LSB    = 25;
    parameter int SEL_LSB   = 23;
    parameter int IMM_D_BIT = 22;
    parameter int IMM_S_BIT = 21;
    parameter logic [OP_W-1:0] PFX_OPC = 7'h5E;
    localparam int NUM_FIELDS = 2;

    typedef struct packed {
        logic               pend_d;
        logic               pend_s;
        logic [FIELD_W-1:0] off_d;
        logic [FIELD_W-1:0] off_s;
    } opatch_state_t;
endpackage

// File: rtl/opatch_decode.sv
module opatch_decode
    import opatch_pkg::*;
(
    input  logic [WORD_W-1:0]  word,
    input  logic [WORD_W-1:0]  rd_d,
    input  logic [WORD_W-1:0]  rd_s,
    output logic               is_pfx,
    output logic               set_d,
    output logic               set_s,
    output logic [FIELD_W-1:0] off_d,
    output logic [FIELD_W-1:0] off_s
);
    logic [1:0] sel;

    always_comb begin
        sel    = word[SEL_LSB +: 2];
        is_pfx = (word[OP_LSB +: OP_W] == PFX_OPC) && (sel != 2'b00);
        set_d  = is_pfx && sel[0];
        set_s  = is_pfx && sel[1];
        off_d  = word[IMM_D_BIT] ? word[D_LSB +: FIELD_W] : rd_d[FIELD_W-1:0];
        off_s  = word[IMM_S_BIT] ? word[S_LSB +: FIELD_W] : rd_s[FIELD_W-1:0];
    end
endmodule

// File: rtl/opatch_field.sv
module opatch_field #(
    parameter int W = 9
) (
    input  logic [W-1:0] field_in,
    input  logic         apply,
    input  logic [W-1:0] offset,
    output logic [W-1:0] field_out
);
    logic [W-1:0] sum;

    always_comb begin
        sum       = field_in + offset;
        field_out = apply ? sum : field_in;
    end
endmodule

// File: rtl/opatch_top.sv
module opatch_top
    import opatch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              cancel,
    input  logic [WORD_W-1:0] pfx_rd_d,
    input  logic [WORD_W-1:0] pfx_rd_s,
    output logic [WORD_W-1:0] out_word,
    output logic              out_valid
);
    opatch_state_t state_d, state_q;

    logic               dec_is_pfx, dec_set_d, dec_set_s;
    logic [FIELD_W-1:0] dec_off_d, dec_off_s;
    logic               consume;

    logic [FIELD_W-1:0] fld_in  [NUM_FIELDS];
    logic [FIELD_W-1:0] fld_out [NUM_FIELDS];
    logic [FIELD_W-1:0] fld_off [NUM_FIELDS];
    logic               fld_en  [NUM_FIELDS];

    opatch_decode u_dec (
        .word   (in_word),
        .rd_d   (pfx_rd_d),
        .rd_s   (pfx_rd_s),
        .is_pfx (dec_is_pfx),
        .set_d  (dec_set_d),
        .set_s  (dec_set_s),
        .off_d  (dec_off_d),
        .off_s  (dec_off_s)
    );

    assign consume = in_valid && !dec_is_pfx;

    // index 0 = S field, index 1 = D field
    generate
        for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
            localparam int FLSB = (i == 0) ? S_LSB : D_LSB;
            assign fld_in[i]  = in_word[FLSB +: FIELD_W];
            assign fld_off[i] = (i == 0) ? state_q.off_s : state_q.off_d;
            assign fld_en[i]  = consume && ((i == 0) ? state_q.pend_s : state_q.pend_d);
            opatch_field #(.W(FIELD_W)) u_fld (
                .field_in  (fld_in[i]),
                .apply     (fld_en[i]),
                .offset    (fld_off[i]),
                .field_out (fld_out[i])
            );
        end
    endgenerate

    always_comb begin
        out_word = in_word;
        out_word[S_LSB +: FIELD_W] = fld_out[0];
        out_word[D_LSB +: FIELD_W] = fld_out[1];
        out_valid = in_valid && !cancel;
    end

    always_comb begin
        state_d = state_q;
        if (in_valid) begin
            if (cancel || !dec_is_pfx) begin
                state_d = '0;
            end else begin
                state_d.pend_d = dec_set_d;
                state_d.pend_s = dec_set_s;
                state_d.off_d  = dec_off_d;
                state_d.off_s  = dec_off_s;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/opatch_checker.sv
module opatch_checker
    import opatch_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_word,
    input logic              cancel,
    input logic [WORD_W-1:0] out_word,
    input logic              out_valid
);
    logic chk_pfx;
    assign chk_pfx = (in_word[OP_LSB +: OP_W] == PFX_OPC) && (in_word[SEL_LSB +: 2] != 2'b00);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (out_word == in_word));

    assert_high_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_word[WORD_W-1:D_LSB+FIELD_W] == in_word[WORD_W-1:D_LSB+FIELD_W]);

    assert_cancel_kills_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |-> !out_valid);

    assert_cancel_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cancel) |=> (out_word == in_word));

    assert_prefix_untouched_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && chk_pfx) |-> (out_word == in_word));

    assert_one_shot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !chk_pfx) |=> (out_word == in_word));

    assert_zero_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cancel && chk_pfx && in_word[SEL_LSB +: 2] == 2'b10 && in_word[IMM_S_BIT])
        |=> (!(in_valid && !chk_pfx && in_word[S_LSB +: FIELD_W] == '0)
             || out_word[S_LSB +: FIELD_W] == $past(in_word[S_LSB +: FIELD_W])));
endmodule

bind opatch_top opatch_checker u_opatch_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .cancel    (cancel),
    .out_word  (out_word),
    .out_valid (out_valid)
);

// File: tb/opatch_top_bench.sv
module opatch_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        cancel = 1'b0;
    logic [31:0] pfx_rd_d = '0;
    logic [31:0] pfx_rd_s = '0;
    logic [31:0] out_word;
    logic        out_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    opatch_top u_opatch_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .cancel(cancel), .pfx_rd_d(pfx_rd_d), .pfx_rd_s(pfx_rd_s),
        .out_word(out_word), .out_valid(out_valid)
    );

    function automatic logic [31:0] mk_pfx(input logic [1:0] sel, input logic imd,
                                           input logic ims, input logic [8:0] d,
                                           input logic [8:0] s);
        return {7'h5E, sel, imd, ims, 3'b000, d, s};
    endfunction

    function automatic logic [31:0] mk_ins(input logic [13:0] hi, input logic [8:0] d,
                                           input logic [8:0] s);
        return {hi, d, s};
    endfunction

    task automatic cyc(input logic v, input logic [31:0] w, input logic c,
                       input logic [31:0] rdd, input logic [31:0] rds,
                       output logic [31:0] ow, output logic ov);
        @(negedge clk);
        in_valid = v; in_word = w; cancel = c; pfx_rd_d = rdd; pfx_rd_s = rds;
        #1;
        ow = out_word; ov = out_valid;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] ow, w;
        logic        ov;
        logic [8:0]  fv [5];
        logic [8:0]  offv [4];
        fv[0] = 9'd0; fv[1] = 9'd1; fv[2] = 9'd255; fv[3] = 9'd300; fv[4] = 9'd511;
        offv[0] = 9'd0; offv[1] = 9'd1; offv[2] = 9'd211; offv[3] = 9'd511;

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: fresh after reset
        w = mk_ins(14'h0471, 9'd33, 9'd77);
        cyc(1, w, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, ow, ov);
        chk("R1 word", ow, w);
        chk("R1 valid", {31'd0, ov}, 32'd1);

        // R2: plain pass-through
        w = mk_ins(14'h2ABC, 9'd400, 9'd5);
        cyc(1, w, 0, 0, 0, ow, ov);
        chk("R2", ow, w);

        // Sweep: R3 R4 R5 R6 R7 R10 R12 R8
        for (int sel = 1; sel < 4; sel++) begin
            for (int im = 0; im < 4; im++) begin
                for (int o = 0; o < 4; o++) begin
                    for (int f = 0; f < 5; f++) begin
                        logic [8:0] od, os, fd, fs;
                        logic [31:0] pw, nw, ew, rdd, rds;
                        string req;
                        od = offv[o]; os = offv[(o + 1) % 4];
                        fs = fv[f]; fd = fv[(f + 2) % 5];
                        rdd = {23'h5A5A5A, od}; rds = {23'h3C3C3C, os};
                        pw = mk_pfx(sel[1:0], im[1], im[0],
                                    im[1] ? od : 9'd99, im[0] ? os : 9'd17);
                        if (!im[1]) rdd = {23'h5A5A5A, od}; else rdd = 32'hFFFF_FE00;
                        if (!im[0]) rds = {23'h3C3C3C, os}; else rds = 32'hFFFF_FE00;
                        cyc(1, pw, 0, rdd, rds, ow, ov);
                        chk("R10 prefix unmodified", ow, pw);
                        nw = mk_ins(14'h1234 ^ 14'(f * 7 + o), fd, fs);
                        ew = nw;
                        if (sel[0]) ew[17:9] = fd + od;
                        if (sel[1]) ew[8:0]  = fs + os;
                        req = (sel == 1) ? "R3 R6 R7 R12" : (sel == 2) ? "R4 R6 R7 R12" : "R5 R6 R7 R12";
                        cyc(1, nw, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, ow, ov);
                        chk(req, ow, ew);
                        cyc(1, nw, 0, 0, 0, ow, ov);
                        chk("R8 consumed once", ow, nw);
                    end
                end
            end
        end

        // R8: idle gap does not consume
        cyc(1, mk_pfx(2'b10, 1'b0, 1'b1, 9'd0, 9'd40), 0, 0, 0, ow, ov);
        cyc(0, mk_ins(14'h0100, 9'd1, 9'd2), 0, 0, 0, ow, ov);
        chk("R8 idle valid", {31'd0, ov}, 32'd0);
        w = mk_ins(14'h0100, 9'd3, 9'd2);
        cyc(1, w, 0, 0, 0, ow, ov);
        chk("R8 after gap", ow, {w[31:9], 9'd42});

        // R9: cancelled consumer discards pending
        cyc(1, mk_pfx(2'b11, 1'b1, 1'b1, 9'd10, 9'd20), 0, 0, 0, ow, ov);
        cyc(1, mk_ins(14'h0200, 9'd1, 9'd1), 1, 0, 0, ow, ov);
        chk("R9 cancel valid", {31'd0, ov}, 32'd0);
        w = mk_ins(14'h0200, 9'd1, 9'd1);
        cyc(1, w, 0, 0, 0, ow, ov);
        chk("R9 discarded", ow, w);

        // R9: cancelled prefix records nothing
        cyc(1, mk_pfx(2'b01, 1'b1, 1'b0, 9'd50, 9'd0), 1, 0, 0, ow, ov);
        w = mk_ins(14'h0300, 9'd9, 9'd9);
        cyc(1, w, 0, 0, 0, ow, ov);
        chk("R9 cancelled prefix", ow, w);

        // R10: back-to-back prefixes, second replaces first
        cyc(1, mk_pfx(2'b01, 1'b1, 1'b0, 9'd5, 9'd0), 0, 0, 0, ow, ov);
        w = mk_pfx(2'b10, 1'b0, 1'b0, 9'd0, 9'd0);
        cyc(1, w, 0, 32'd0, 32'hABCD_E007, ow, ov);
        chk("R10 second prefix unmodified", ow, w);
        w = mk_ins(14'h0400, 9'd100, 9'd200);
        cyc(1, w, 0, 0, 0, ow, ov);
        chk("R10 replace", ow, {w[31:18], 9'd100, 9'd207});

        // R11: prefix opcode with selector 00 is ordinary
        w = mk_pfx(2'b00, 1'b1, 1'b1, 9'd60, 9'd70);
        cyc(1, w, 0, 0, 0, ow, ov);
        chk("R11 sel00 passes", ow, w);
        w = mk_ins(14'h0500, 9'd4, 9'd4);
        cyc(1, w, 0, 0, 0, ow, ov);
        chk("R11 sel00 records nothing", ow, w);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule